// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Arbiter

This block gathers six interrupt request lines (two external pins, three timers and one serial port) and turns them into one request and one vector index for a processor core. Each line passes through a software-visible enable mask and a master enable, and software assigns it one of two urgency levels. Among the requests that survive the masks, the arbiter picks one winner and shows its index on the vector output while the request output is high.

The arbiter remembers which urgency levels have a handler running. A handler at the upper level can interrupt one at the lower level. A request cannot interrupt a handler running at its own level or above. When the core takes the request, it pulses an acknowledge strobe. The arbiter then marks that level busy and sends a one-cycle clear pulse back to the winning source, so edge-captured flags can drop. The timer 2 line gets no clear pulse, because its owner clears it by software. A return strobe retires the most urgent busy level.

Top module: `intc_top`

## Requirements
- R1: After reset the request output, every acknowledge pulse and the enable readback are all zero, and no level is busy.
- R2: The enable register is 9 bits wide. Bits 0..4 enable ext0, tmr0, ext1, tmr1 and serial. Bit 8 enables tmr2 and bit 7 is the master enable. Bits 5 and 6 are not stored, and the readback shows 0 in those positions whatever was written there.
- R3: While the master enable (bit 7) is 0, the request output stays low whatever the request lines and per-source bits are.
- R4: A source whose own enable bit is 0 never becomes the presented vector.
- R5: Lines ext0, ext1, serial and tmr2 become visible after one clock edge. Lines tmr0 and tmr1 become visible only after a second edge, so one cycle later.
- R6: Vector indices are ext0=0, tmr0=1, ext1=2, tmr1=3, serial=4, tmr2=5. Within one level, the lowest index that is pending wins.
- R7: The urgency register is 6 bits. Bit i=1 puts source i at the upper level. Any pending upper-level source wins over every lower-level source.
- R8: A request is presented only if its level is above every busy level. With the upper level busy, the request output is low. With the lower level busy, only upper-level sources are presented.
- R9: An acknowledge while the request output is high marks the winner's level busy. On the next cycle it raises the winner's bit of the acknowledge output for exactly one cycle.
- R10: Acknowledge output bit 5 (tmr2) never pulses.
- R11: A return strobe clears the upper busy level if it is set, and otherwise clears the lower one.
- R12: An acknowledge while the request output is low changes nothing and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqRaw | input | 6 | Raw request lines, indexed as in R6 |
| enWr | input | 1 | Write strobe for the enable register |
| enWrData | input | 9 | Enable register write data |
| prWr | input | 1 | Write strobe for the urgency register |
| prWrData | input | 6 | Urgency register write data |
| ackIn | input | 1 | Core takes the presented request |
| retiIn | input | 1 | Core leaves the current handler |
| irq | output | 1 | Request to the core |
| vec | output | 3 | Index of the presented source |
| ackOut | output | 6 | One-cycle clear pulse per source |
| enRd | output | 9 | Enable register readback |

## Verification
The checker watches several rules on every cycle: the reserved readback bits, master-enable silencing, and that the presented vector is enabled. It also checks the total block while the upper level is busy, the one-hot acknowledge pulse that matches the vector taken, the absence of a tmr2 clear, and the retirement of the upper level first. Some behaviour only the bench scenarios can show. This covers the two sampling latencies and the fixed winner order, swept over every request pattern against every urgency assignment. It also covers nesting sequences, where a handler blocks its own level and is later reopened by a return.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC   = 6;
  localparam int VEC_W     = $clog2(NUM_SRC);
  localparam int NUM_LVL   = 2;
  localparam int EN_W      = 9;
  localparam int GLOBAL_BIT = 7;
  localparam int RSVD_LO   = 5;
  localparam int TMR2_EN_BIT = 8;

  // sources sampled one extra cycle late (tmr0, tmr1)
  localparam logic [NUM_SRC-1:0] LATE_MASK   = 6'b001010;
  // sources that receive no clear pulse (tmr2)
  localparam logic [NUM_SRC-1:0] NO_ACK_MASK = 6'b100000;
  localparam logic [EN_W-1:0]    RSVD_MASK   = EN_W'(2'b11) << RSVD_LO;

  typedef struct packed {
    logic             take;
    logic [VEC_W-1:0] vec;
  } ctlStrobe_t;

  function automatic int enBitOf(input int src);
    return (src == NUM_SRC - 1) ? TMR2_EN_BIT : src;
  endfunction
endpackage

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqRaw,
  input  logic               enWr,
  input  logic [EN_W-1:0]    enWrData,
  input  logic               prWr,
  input  logic [NUM_SRC-1:0] prWrData,
  input  ctlStrobe_t         strobe,
  output logic [NUM_SRC-1:0] pending,
  output logic [NUM_SRC-1:0] prio,
  output logic [EN_W-1:0]    enRd,
  output logic [NUM_SRC-1:0] ackOut
);
  logic [EN_W-1:0]    enReg;
  logic [NUM_SRC-1:0] stage1;
  logic [NUM_SRC-1:0] seen;
  logic [NUM_SRC-1:0] srcEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= '0;
      prio  <= '0;
    end else begin
      if (enWr) enReg <= enWrData & ~RSVD_MASK;
      if (prWr) prio  <= prWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stage1 <= '0;
    else       stage1 <= reqRaw;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int EB = enBitOf(i);
    assign srcEn[i] = enReg[EB];
    if (LATE_MASK[i]) begin : g_late
      logic stage2;
      always_ff @(posedge clk) begin
        if (!rstN) stage2 <= 1'b0;
        else       stage2 <= stage1[i];
      end
      assign seen[i] = stage2;
    end else begin : g_early
      assign seen[i] = stage1[i];
    end
  end

  assign pending = seen & srcEn & {NUM_SRC{enReg[GLOBAL_BIT]}};
  assign enRd    = enReg;

  always_ff @(posedge clk) begin
    if (!rstN)            ackOut <= '0;
    else if (strobe.take) ackOut <= (NUM_SRC'(1) << strobe.vec) & ~NO_ACK_MASK;
    else                  ackOut <= '0;
  end
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pending,
  input  logic [NUM_SRC-1:0] prio,
  input  logic               ackIn,
  input  logic               retiIn,
  output logic               irq,
  output logic [VEC_W-1:0]   vec,
  output ctlStrobe_t         strobe,
  output logic [NUM_LVL-1:0] inSvc
);
  logic [NUM_SRC-1:0] hiPend, loPend;
  logic               hiOk, loOk;
  logic [NUM_LVL-1:0] inSvcNxt;

  function automatic logic [VEC_W-1:0] firstSet(input logic [NUM_SRC-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (v[i]) r = VEC_W'(i);
    return r;
  endfunction

  assign hiPend = pending & prio;
  assign loPend = pending & ~prio;
  assign hiOk   = (|hiPend) && !inSvc[1];
  assign loOk   = (|loPend) && (inSvc == '0);
  assign irq    = hiOk || loOk;
  assign vec    = hiOk ? firstSet(hiPend) : (loOk ? firstSet(loPend) : '0);

  assign strobe.take = ackIn && irq;
  assign strobe.vec  = vec;

  always_comb begin
    inSvcNxt = inSvc;
    if (retiIn) begin
      if (inSvcNxt[1]) inSvcNxt[1] = 1'b0;
      else             inSvcNxt[0] = 1'b0;
    end
    if (strobe.take) inSvcNxt[hiOk] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) inSvc <= '0;
    else       inSvc <= inSvcNxt;
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqRaw,
  input  logic               enWr,
  input  logic [EN_W-1:0]    enWrData,
  input  logic               prWr,
  input  logic [NUM_SRC-1:0] prWrData,
  input  logic               ackIn,
  input  logic               retiIn,
  output logic               irq,
  output logic [VEC_W-1:0]   vec,
  output logic [NUM_SRC-1:0] ackOut,
  output logic [EN_W-1:0]    enRd
);
  ctlStrobe_t         strobe;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] prio;
  logic [NUM_LVL-1:0] inSvc;

  intc_datapath dp_i (
    .clk(clk), .rstN(rstN), .reqRaw(reqRaw),
    .enWr(enWr), .enWrData(enWrData), .prWr(prWr), .prWrData(prWrData),
    .strobe(strobe), .pending(pending), .prio(prio),
    .enRd(enRd), .ackOut(ackOut)
  );

  intc_control ctl_i (
    .clk(clk), .rstN(rstN), .pending(pending), .prio(prio),
    .ackIn(ackIn), .retiIn(retiIn), .irq(irq), .vec(vec),
    .strobe(strobe), .inSvc(inSvc)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               irq,
  input logic [VEC_W-1:0]   vec,
  input logic               ackIn,
  input logic               retiIn,
  input logic [NUM_SRC-1:0] ackOut,
  input logic [EN_W-1:0]    enRd,
  input logic [NUM_LVL-1:0] inSvc
);
  function automatic logic srcEnabled(input logic [EN_W-1:0] e, input logic [VEC_W-1:0] v);
    case (v)
      3'd0: return e[0];
      3'd1: return e[1];
      3'd2: return e[2];
      3'd3: return e[3];
      3'd4: return e[4];
      3'd5: return e[TMR2_EN_BIT];
      default: return 1'b0;
    endcase
  endfunction

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    enRd[6:5] == 2'b00);

  p_global_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !enRd[GLOBAL_BIT] |-> !irq);

  p_vec_enabled_r4: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> srcEnabled(enRd, vec));

  p_hi_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    inSvc[1] |-> !irq);

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && irq) |=> (ackOut == ((NUM_SRC'(1) << $past(vec)) & ~NO_ACK_MASK)));

  p_ack_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackOut));

  p_no_tmr2_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ackOut[NUM_SRC-1]);

  p_reti_hi_first_r11: assert property (@(posedge clk) disable iff (!rstN)
    (retiIn && !ackIn && inSvc == 2'b11) |=> (inSvc == 2'b01));

  p_ack_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ackIn && !irq) |=> (ackOut == '0) && $stable(inSvc));
endmodule

bind intc_top intc_checker chk_i (
  .clk(clk), .rstN(rstN), .irq(irq), .vec(vec), .ackIn(ackIn),
  .retiIn(retiIn), .ackOut(ackOut), .enRd(enRd), .inSvc(inSvc)
);

// File: tb/intc_top_tb_top.sv
`timescale 1ns/1ps
module intc_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] reqRaw = '0;
  logic       enWr = 1'b0;
  logic [8:0] enWrData = '0;
  logic       prWr = 1'b0;
  logic [5:0] prWrData = '0;
  logic       ackIn = 1'b0;
  logic       retiIn = 1'b0;
  logic       irq;
  logic [2:0] vec;
  logic [5:0] ackOut;
  logic [8:0] enRd;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  intc_top dut_i (
    .clk(clk), .rstN(rstN), .reqRaw(reqRaw), .enWr(enWr), .enWrData(enWrData),
    .prWr(prWr), .prWrData(prWrData), .ackIn(ackIn), .retiIn(retiIn),
    .irq(irq), .vec(vec), .ackOut(ackOut), .enRd(enRd)
  );

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeEn(input logic [8:0] d);
    enWrData = d; enWr = 1'b1; tick(); enWr = 1'b0;
  endtask

  task automatic writePr(input logic [5:0] d);
    prWrData = d; prWr = 1'b1; tick(); prWr = 1'b0;
  endtask

  task automatic ack();
    ackIn = 1'b1; tick(); ackIn = 1'b0;
  endtask

  task automatic reti();
    retiIn = 1'b1; tick(); retiIn = 1'b0;
  endtask

  function automatic int lowestSet(input logic [5:0] v);
    for (int i = 0; i < 6; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic int enBit(input int s);
    return (s == 5) ? 8 : s;
  endfunction

  task automatic finish();
    $display("  %0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    tick(3);
    // R1: reset state
    check("R1 irq", irq, 0);
    check("R1 ackOut", ackOut, 0);
    check("R1 enRd", enRd, 0);
    rstN = 1'b1;
    tick();
    check("R1 irq after release", irq, 0);

    // R2: reserved enable bits read zero
    writeEn(9'h1FF);
    check("R2 readback all", enRd, 9'h19F);
    writeEn(9'h060);
    check("R2 reserved only", enRd, 0);

    // R5: sampling latency per source
    writeEn(9'h19F);
    writePr(6'h00);
    for (int i = 0; i < 6; i++) begin
      reqRaw = 6'(1 << i);
      tick();
      check($sformatf("R5 early irq src%0d", i), irq, (i == 1 || i == 3) ? 0 : 1);
      tick();
      check($sformatf("R5 late irq src%0d", i), irq, 1);
      check($sformatf("R5 vec src%0d", i), vec, i);
      reqRaw = '0;
      tick(3);
    end

    // R3: master enable off silences everything
    reqRaw = 6'h3F;
    writeEn(9'h17F);
    tick(3);
    check("R3 master off", irq, 0);

    // R4: only the enabled source can win
    for (int i = 0; i < 6; i++) begin
      writeEn(9'(1 << enBit(i)) | 9'h080);
      tick();
      check($sformatf("R4 irq only src%0d", i), irq, 1);
      check($sformatf("R4 vec only src%0d", i), vec, i);
    end
    writeEn(9'h080);
    check("R4 none enabled", irq, 0);
    reqRaw = '0;
    writeEn(9'h19F);
    tick(3);

    // R12: acknowledge with nothing pending is ignored
    ack();
    check("R12 no pulse", ackOut, 0);
    tick();
    reqRaw = 6'h01;
    tick(3);
    check("R12 level not busied", irq, 1);
    reqRaw = '0;
    tick(3);

    // R8/R11: nesting, ext1 and serial at upper level
    writePr(6'b010100);
    reqRaw = 6'b000001;
    tick(3);
    check("R8 low taken vec", vec, 0);
    ack();
    check("R9 ack ext0", ackOut, 6'h01);
    reqRaw = 6'b000010;
    tick(3);
    check("R8 low blocks low", irq, 0);
    reqRaw = 6'b010010;
    tick(3);
    check("R8 high preempts irq", irq, 1);
    check("R8 high preempts vec", vec, 4);
    ack();
    check("R9 ack serial", ackOut, 6'h10);
    reqRaw = 6'b000110;
    tick(3);
    check("R8 high blocks high", irq, 0);
    reti();
    check("R11 upper retired irq", irq, 1);
    check("R11 upper retired vec", vec, 2);
    reti();
    check("R11 lower retired vec", vec, 2);
    reqRaw = 6'b000010;
    tick(3);
    check("R11 all retired irq", irq, 1);
    check("R11 all retired vec", vec, 1);
    reqRaw = '0;
    tick(3);

    // R6/R7/R9/R10/R11: sweep all urgency maps and request patterns
    for (int p = 0; p < 64; p++) begin
      writePr(6'(p));
      for (int r = 1; r < 64; r++) begin
        logic [5:0] hi;
        int w;
        int wHi;
        hi  = 6'(r) & 6'(p);
        w   = (hi != 0) ? lowestSet(hi) : lowestSet(6'(r) & ~6'(p));
        wHi = (hi != 0) ? 1 : 0;
        reqRaw = 6'(r);
        tick(3);
        check("R6 R7 irq", irq, 1);
        check($sformatf("R6 R7 vec p=%0h r=%0h", p, r), vec, w);
        ack();
        check($sformatf("R9 R10 pulse p=%0h r=%0h", p, r), ackOut,
              (w == 5) ? 0 : (1 << w));
        check("R8 after take", irq, wHi ? 0 : ((hi != 0) ? 1 : 0));
        tick();
        check("R9 single pulse", ackOut, 0);
        reti();
        reqRaw = '0;
        tick(3);
        check("R11 idle after return", irq, 0);
      end
    end

    finish();
  end
endmodule